// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block gathers interrupt requests from eight device lines and presents one of them at a time to a processor. A rising edge on a line latches a pending request. An in-service register records which levels the processor is currently handling. Line 0 outranks line 7. The controller raises its interrupt output only when the best pending request outranks every level that is already in service. A lower-priority or equal request therefore waits until the higher levels are retired.

The processor answers with two active-low acknowledge pulses. On the first pulse the controller commits the winning level to the in-service register and clears its pending bit. On the second pulse it places an 8-bit vector on the data bus. The vector is a programmed 5-bit base in bits 7:3 and the level number in bits 2:0. End-of-interrupt commands retire levels. A specific command names the level to clear. A non-specific command clears the highest-priority level in service.

Several controllers can share one processor. A select pin makes a controller a master or a slave. A master lists the inputs that have slaves behind them. When it grants such an input, it drives the level number on the 3-bit cascade bus and stays off the data bus. A slave compares the cascade bus with its own identity at the end of the first pulse. Only the matching slave commits and supplies the vector.

Top module: `pic_core`

## Requirements
- R1: After reset the interrupt output, the data-bus enable and the cascade-bus enable are all low, and no level is in service.
- R2: A low-to-high transition on a request line latches a pending request. A line that stays high raises no further request after that request has been granted and retired.
- R3: When several requests are pending, the lowest-numbered one is granted, and the vector's bits 2:0 carry its number.
- R4: The interrupt output is high only while the controller is idle between acknowledge sequences and some pending request's number is lower than the number of every level in service. An equal or higher-numbered request leaves it low.
- R5: The first acknowledge pulse is seen at a clock edge. From the following cycle the interrupt output is low, and the granted level is set in service. While the second pulse is low, the granting controller asserts the data enable with data = {base[4:0], level[2:0]}. At most one level enters service per cycle.
- R6: An end-of-interrupt strobe with the specific flag set clears only the named level. With the flag clear, it clears the lowest-numbered level in service. The remaining pending requests are then re-evaluated under R4.
- R7: As master, granting an input whose bit is set in the slave mask drives the cascade bus with that input's number, with the cascade enable high from the first pulse through the second. The data enable stays low. Granting an unmasked input leaves the cascade enable low.
- R8: As slave, the controller never enables the cascade bus. It commits and drives its vector only if the cascade input equals its identity at the end of the first pulse. Otherwise it leaves the data bus off, and its request stays pending.
- R9: An acknowledge with no eligible request returns the vector for level 7 and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Device request lines, 0 highest priority |
| inta_ni | input | 1 | Active-low interrupt acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt command strobe, one cycle |
| eoi_spec_i | input | 1 | 1: clear the level on eoi_lvl_i; 0: clear the highest-priority level in service |
| eoi_lvl_i | input | 3 | Level for a specific end-of-interrupt |
| is_master_i | input | 1 | 1: master, drives the cascade bus; 0: slave, listens to it |
| slave_mask_i | input | 8 | Master only: inputs that have a slave attached |
| slave_id_i | input | 3 | Slave only: this controller's cascade identity |
| base_i | input | 5 | Vector base, bits 7:3 of the vector |
| cas_i | input | 3 | Cascade bus as seen by a slave |
| cas_o | output | 3 | Cascade bus value driven by a master |
| cas_oe_o | output | 1 | Cascade bus drive enable |
| intr_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Vector number, zero when not enabled |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The embedded assertions check four things on every cycle. A granted level never has an equal or higher-priority level already in service. The cascade enable and the data enable are never high together. The vector appears only after an acknowledge low sample. Each end-of-interrupt command removes exactly the bit it should. Whether the right vector number comes out, whether preemption happens for every pair of levels, and whether a slave stays silent on a foreign cascade number can only be shown by the bench. Its scenarios sweep every pair of in-service and new levels, and every pattern of simultaneous requests, under master and slave settings.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned IRQ_N  = 8;
  localparam int unsigned IDX_W  = $clog2(IRQ_N);
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    ACK_IDLE,
    ACK_FIRST,
    ACK_GAP,
    ACK_SECOND
  } ack_state_e;
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture
  import pic_pkg::*;
#(
  parameter int unsigned N = IRQ_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irq_q;
  logic [N-1:0] irr_q;

  // per-line edge detector; a new edge wins over a grant clear
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q[g] <= 1'b0;
        irr_q[g] <= 1'b0;
      end else begin
        irq_q[g] <= irq_i[g];
        irr_q[g] <= (irq_i[g] & ~irq_q[g]) | (irr_q[g] & ~clr_i[g]);
      end
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
  import pic_pkg::*;
#(
  parameter int unsigned N  = IRQ_N,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  isr_i,
  output logic          win_vld_o,
  output logic [IW-1:0] win_idx_o
);
  logic [N-1:0] open_mask;
  logic [N-1:0] elig;
  logic         none_above;

  // a level is open only if no level at or above it is in service
  always_comb begin
    none_above = 1'b1;
    for (int i = 0; i < N; i++) begin
      none_above   = none_above & ~isr_i[i];
      open_mask[i] = none_above;
    end
  end

  assign elig = irr_i & open_mask;

  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_vld_o = 1'b1;
        win_idx_o = IW'(i);
      end
    end
  end

  logic [N-1:0] upto_win;
  always_comb begin
    for (int i = 0; i < N; i++) upto_win[i] = (i <= int'(win_idx_o));
  end

  assert_preempt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (((isr_i & upto_win) == '0) && irr_i[win_idx_o]));
endmodule

// File: rtl/pic_ack_ctrl.sv
module pic_ack_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N  = IRQ_N,
  parameter int unsigned IW = $clog2(N),
  parameter int unsigned DW = DATA_W,
  localparam int unsigned BW = DW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inta_ni,
  input  logic          is_master_i,
  input  logic [N-1:0]  slave_mask_i,
  input  logic [IW-1:0] slave_id_i,
  input  logic [BW-1:0] base_i,
  input  logic [IW-1:0] cas_i,
  input  logic          win_vld_i,
  input  logic [IW-1:0] win_idx_i,
  output logic          idle_o,
  output logic          commit_o,
  output logic [IW-1:0] commit_idx_o,
  output logic [IW-1:0] cas_o,
  output logic          cas_oe_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  ack_state_e    state_q, state_d;
  logic          inta_q;
  logic          ack_fall, ack_rise;
  logic [IW-1:0] g_idx_q;
  logic          g_vld_q;
  logic          sel_q;
  logic          cas_hit;
  logic          m_commit, s_commit;

  assign ack_fall = inta_q & ~inta_ni;
  assign ack_rise = ~inta_q & inta_ni;
  assign cas_hit  = (cas_i == slave_id_i);

  assign m_commit = is_master_i && (state_q == ACK_IDLE) && ack_fall && win_vld_i;
  assign s_commit = !is_master_i && (state_q == ACK_FIRST) && ack_rise && g_vld_q && cas_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE:   if (ack_fall) state_d = ACK_FIRST;
      ACK_FIRST:  if (ack_rise) state_d = ACK_GAP;
      ACK_GAP:    if (ack_fall) state_d = ACK_SECOND;
      ACK_SECOND: if (ack_rise) state_d = ACK_IDLE;
      default:    state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACK_IDLE;
      inta_q  <= 1'b1;
      g_idx_q <= '0;
      g_vld_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      inta_q  <= inta_ni;
      if (state_q == ACK_IDLE && ack_fall) begin
        // no eligible request: answer with the lowest level
        g_idx_q <= win_vld_i ? win_idx_i : IW'(N - 1);
        g_vld_q <= win_vld_i;
        sel_q   <= is_master_i && !(win_vld_i && slave_mask_i[win_idx_i]);
      end else if (state_q == ACK_FIRST && ack_rise && !is_master_i) begin
        sel_q <= cas_hit;
      end else if (state_q == ACK_SECOND && ack_rise) begin
        sel_q <= 1'b0;
      end
    end
  end

  assign idle_o       = (state_q == ACK_IDLE);
  assign commit_o     = m_commit | s_commit;
  assign commit_idx_o = is_master_i ? win_idx_i : g_idx_q;

  assign cas_oe_o  = is_master_i && (state_q != ACK_IDLE) && g_vld_q && slave_mask_i[g_idx_q];
  assign cas_o     = cas_oe_o ? g_idx_q : '0;
  assign data_oe_o = (state_q == ACK_SECOND) && sel_q;
  assign data_o    = data_oe_o ? {base_i, g_idx_q} : '0;

  assert_bus_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_oe_o |-> !data_oe_o);

  assert_vec_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !$past(inta_ni));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int unsigned N  = IRQ_N,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned BW = DW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          inta_ni,
  input  logic          eoi_i,
  input  logic          eoi_spec_i,
  input  logic [IW-1:0] eoi_lvl_i,
  input  logic          is_master_i,
  input  logic [N-1:0]  slave_mask_i,
  input  logic [IW-1:0] slave_id_i,
  input  logic [BW-1:0] base_i,
  input  logic [IW-1:0] cas_i,
  output logic [IW-1:0] cas_o,
  output logic          cas_oe_o,
  output logic          intr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic [N-1:0]  irr;
  logic [N-1:0]  isr_q;
  logic [N-1:0]  set_vec, clr_vec, top_vec;
  logic          win_vld;
  logic [IW-1:0] win_idx;
  logic          idle;
  logic          commit;
  logic [IW-1:0] commit_idx;
  logic          found;

  pic_req_capture #(.N(N)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .clr_i  (set_vec),
    .irr_o  (irr)
  );

  pic_prio_resolve #(.N(N), .IW(IW)) u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irr_i     (irr),
    .isr_i     (isr_q),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx)
  );

  pic_ack_ctrl #(.N(N), .IW(IW), .DW(DW)) u_ack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inta_ni      (inta_ni),
    .is_master_i  (is_master_i),
    .slave_mask_i (slave_mask_i),
    .slave_id_i   (slave_id_i),
    .base_i       (base_i),
    .cas_i        (cas_i),
    .win_vld_i    (win_vld),
    .win_idx_i    (win_idx),
    .idle_o       (idle),
    .commit_o     (commit),
    .commit_idx_o (commit_idx),
    .cas_o        (cas_o),
    .cas_oe_o     (cas_oe_o),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o)
  );

  // highest-priority in-service level, for non-specific EOI
  always_comb begin
    top_vec = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (isr_q[i] && !found) begin
        top_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign set_vec = commit ? (N'(1) << commit_idx) : '0;
  assign clr_vec = !eoi_i ? '0 : (eoi_spec_i ? (N'(1) << eoi_lvl_i) : top_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~clr_vec) | set_vec;
  end

  assign intr_o = idle && win_vld;

  assert_single_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1));

  assert_eoi_spec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && eoi_spec_i && !commit) |=> !isr_q[$past(eoi_lvl_i)]);

  assert_eoi_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !eoi_spec_i && (isr_q != '0) && !commit)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/pic_core_tb.sv
module pic_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       inta_n = 1'b1;
  logic       eoi = 1'b0, eoi_spec = 1'b0;
  logic [2:0] eoi_lvl = '0;
  logic       is_master = 1'b1;
  logic [7:0] slave_mask = '0;
  logic [2:0] slave_id = '0;
  logic [4:0] base = 5'h04;
  logic [2:0] cas_in = '0;
  logic [2:0] cas_out;
  logic       cas_oe, intr, data_oe;
  logic [7:0] data;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pic_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .inta_ni(inta_n),
    .eoi_i(eoi), .eoi_spec_i(eoi_spec), .eoi_lvl_i(eoi_lvl),
    .is_master_i(is_master), .slave_mask_i(slave_mask), .slave_id_i(slave_id),
    .base_i(base), .cas_i(cas_in), .cas_o(cas_out), .cas_oe_o(cas_oe),
    .intr_o(intr), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    irq = m;
    @(negedge clk);
    irq = '0;
    @(negedge clk);
  endtask

  task automatic eoi_top();
    eoi = 1; eoi_spec = 0;
    @(negedge clk);
    eoi = 0;
  endtask

  task automatic eoi_at(input logic [2:0] l);
    eoi = 1; eoi_spec = 1; eoi_lvl = l;
    @(negedge clk);
    eoi = 0; eoi_spec = 0;
  endtask

  // two acknowledge pulses of two cycles each
  task automatic ack(output logic [7:0] v, output bit oe, output bit idur,
                     output bit coe1, output logic [2:0] cv1, output bit coe2);
    inta_n = 0;
    @(negedge clk);
    idur = intr; coe1 = cas_oe; cv1 = cas_out;
    @(negedge clk);
    inta_n = 1;
    @(negedge clk);
    inta_n = 0;
    @(negedge clk);
    v = data; oe = data_oe; coe2 = cas_oe;
    @(negedge clk);
    inta_n = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R5 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v; logic [2:0] cv;
    bit oe, idur, coe1, coe2;
    do_reset();
    chk("R1 intr", intr, 0);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 cas_oe", cas_oe, 0);

    // every in-service level against every new level
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 8; m++) begin
        pulse(8'(1 << n));
        chk("R2 intr on edge", intr, 1);
        ack(v, oe, idur, coe1, cv, coe2);
        chk("R5 vector", v, 32 + n);
        chk("R5 data_oe", oe, 1);
        chk("R5 intr drop", idur, 0);
        pulse(8'(1 << m));
        if (m < n) begin
          chk("R4 preempt", intr, 1);
          ack(v, oe, idur, coe1, cv, coe2);
          chk("R4 nested vector", v, 32 + m);
          eoi_top();
          chk("R6 top clear", intr, 0);
          eoi_top();
          chk("R6 second clear", intr, 0);
        end else begin
          chk("R4 blocked", intr, 0);
          eoi_top();
          chk("R6 reevaluate", intr, 1);
          ack(v, oe, idur, coe1, cv, coe2);
          chk("R6 vector after eoi", v, 32 + m);
          eoi_top();
          chk("R6 drained", intr, 0);
        end
      end
    end

    // every pattern of simultaneous requests
    for (int p = 1; p < 256; p++) begin
      pulse(8'(p));
      for (int k = 0; k < 8; k++) begin
        if (p[k]) begin
          chk("R3 pending", intr, 1);
          ack(v, oe, idur, coe1, cv, coe2);
          chk("R3 lowest wins", v, 32 + k);
          chk("R4 lower blocked", intr, 0);
          eoi_top();
        end
      end
      chk("R3 all served", intr, 0);
    end

    // held line: one request only
    irq[4] = 1;
    repeat (2) @(negedge clk);
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R2 held vector", v, 36);
    eoi_top();
    @(negedge clk);
    chk("R2 held no repeat", intr, 0);
    irq[4] = 0;
    @(negedge clk);

    // specific EOI
    pulse(8'h20);
    ack(v, oe, idur, coe1, cv, coe2);
    pulse(8'h04);
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R6 preempt vec", v, 34);
    eoi_at(3'd5);
    pulse(8'h10);
    chk("R6 specific keeps 2", intr, 0);
    eoi_at(3'd2);
    chk("R6 specific clears 2", intr, 1);
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R6 vector 4", v, 36);
    eoi_top();
    chk("R6 idle", intr, 0);

    // spurious acknowledge
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R9 spurious vector", v, 39);
    chk("R9 spurious oe", oe, 1);
    pulse(8'h80);
    chk("R9 isr untouched", intr, 1);
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R9 level7 vector", v, 39);
    eoi_top();

    // master cascade
    slave_mask = 8'h04;
    pulse(8'h04);
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R7 cas_oe first", coe1, 1);
    chk("R7 cas value", cv, 2);
    chk("R7 cas_oe second", coe2, 1);
    chk("R7 no data", oe, 0);
    eoi_top();
    pulse(8'h08);
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R7 unmasked no cas", coe1, 0);
    chk("R7 unmasked data", oe, 1);
    chk("R7 unmasked vector", v, 35);
    eoi_top();

    // slave
    is_master = 0; slave_id = 3'd2; base = 5'h05; slave_mask = 8'hFF;
    do_reset();
    pulse(8'h08);
    chk("R8 slave intr", intr, 1);
    cas_in = 3'd2;
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R8 match oe", oe, 1);
    chk("R8 match vector", v, 43);
    chk("R8 slave no cas", coe1 | coe2, 0);
    eoi_top();
    pulse(8'h02);
    cas_in = 3'd5;
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R8 mismatch silent", oe, 0);
    chk("R8 still pending", intr, 1);
    cas_in = 3'd2;
    ack(v, oe, idur, coe1, cv, coe2);
    chk("R8 retry vector", v, 41);
    chk("R8 retry oe", oe, 1);
    eoi_top();
    chk("R8 drained", intr, 0);

    finish_run();
  end
endmodule